// File: doc/BRIEF.md
# Combined-Control Performance Counter Unit

This block counts processor activity for profiling. It holds one free-running cycle counter and two event counters, all 32 bits wide. Each event counter picks one line out of a vector of single-cycle event pulses through an 8-bit selection code, and adds one for every cycle in which that line is high. One control word carries everything else: the global enable, a slowed cycle-count mode, two self-clearing reset strobes, an interrupt enable per counter, a sticky overflow flag per counter and both selection codes.

Software reaches the unit through a plain register port. A 2-bit index picks the control word or one of the three counters. A write takes effect at the next clock edge. A read is combinational from the index. When a counter wraps past its all-ones value, its flag is set. The flag stays set until software writes a 1 to that bit position in the control word. The interrupt line is high while any flag is set and that flag's enable bit is also set.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset all three counters read zero, the control word reads 0x0FFFF000 (both selection codes 0xFF, everything else clear) and `irq` is low.
- R2: Control bits 31:28, 11 and 7 always read zero, whatever was written. The reset strobes at bits 1 and 2 also always read zero.
- R3: With bit 0 (enable) set and bit 3 (slowed mode) clear, the cycle counter rises by exactly one per clock. With bit 0 clear, it holds its value.
- R4: With bits 0 and 3 both set, the cycle counter rises exactly once every `SLOW_DIV` clocks.
- R5: Event counter 0 uses the code in bits 19:12 and event counter 1 uses the code in bits 27:20. While enabled, a counter adds one in each cycle in which `evt_in[code]` is high. It adds nothing when the code is 0xFF, when the code is `NUM_EVT` or greater, or when bit 0 is clear.
- R6: Writing control with bit 1 set clears both event counters at that edge. Writing control with bit 2 set clears the cycle counter at that edge. Neither bit affects the other counters.
- R7: When a counter steps from 0xFFFFFFFF, it becomes 0 and sets its flag. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R8: Writing a 1 to a flag bit clears that flag. Writing a 0 to it leaves it unchanged.
- R9: `irq` is high exactly when some flag is set together with its enable bit. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R10: A write to a counter in the same cycle as an increment loads the written value, and the increment is dropped.
- R11: Index 0 selects the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 2 | Register index for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_idx` (combinational) |
| evt_in | input | NUM_EVT | Event pulse lines, one per selection code |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with `SLOW_DIV` = 8 and `NUM_EVT` = 23, so codes 0x00 to 0x16 select a line. With the divider at 8, a 40-clock window checks the slowed mode exactly, whatever the prescaler phase, in a short run. With 23 lines, code 0x1F lands above the vector and code 0xFF is the idle code, so both "count nothing" cases are reachable. Counters are preloaded near 0xFFFFFFFF, so every wrap and flag path needs only a few clocks.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int CTRL_W   = 32;
    localparam int SEL_W    = 8;
    localparam int B_EN     = 0;
    localparam int B_RST_EV = 1;
    localparam int B_RST_CY = 2;
    localparam int B_SLOW   = 3;
    localparam int B_IE_LSB = 4;   // ev0, ev1, cycle
    localparam int B_OF_LSB = 8;   // ev0, ev1, cycle
    localparam int SEL0_LSB = 12;
    localparam int SEL1_LSB = 20;
    // stored bits: enable, slow, interrupt enables, flags, both selects
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 32'h0FFF_F779;
    localparam logic [SEL_W-1:0]  SEL_IDLE  = 8'hFF;

    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_CYC  = 2'd1,
        IDX_EV0  = 2'd2,
        IDX_EV1  = 2'd3
    } reg_idx_e;

    // index 0: event counter 0, 1: event counter 1, 2: cycle counter
    typedef struct packed {
        logic             en;
        logic             slow;
        logic [2:0]       ie;
        logic [2:0]       ovf;
        logic [SEL_W-1:0] sel0;
        logic [SEL_W-1:0] sel1;
    } ctrl_t;
endpackage

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
    parameter int NUM_EVT = 23,
    parameter int SEL_W   = 8
) (
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [SEL_W-1:0]   code,
    output logic               hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (code == SEL_W'(i)) hit = evt_in[i];
        end
    end
endmodule

// File: rtl/pmu_slow_tick.sv
module pmu_slow_tick #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        tick  = 1'b0;
        if (run) begin
            if (div_q == LAST) begin
                div_d = '0;
                tick  = 1'b1;
            end else begin
                div_d = div_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    // priority: load, then clear, then increment
    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
            wrap  = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_EVT  = 23,
    parameter int SLOW_DIV = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_idx,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    localparam int NUM_EV_CNT = 2;

    ctrl_t st_d, st_q;

    logic             ctrl_wr;
    logic [31:0]      ctrl_w;
    logic             rst_ev_stb, rst_cy_stb;
    logic             slow_tick, cyc_inc, cyc_wrap;
    logic [CNT_W-1:0] cyc_cnt;
    logic [SEL_W-1:0] ev_sel  [NUM_EV_CNT];
    logic [CNT_W-1:0] ev_cnt  [NUM_EV_CNT];
    logic [NUM_EV_CNT-1:0] ev_hit, ev_wrap;
    logic [2:0]       ovf_flags, ie_bits;

    assign ctrl_wr    = wr_en && (reg_idx == IDX_CTRL);
    assign ctrl_w     = wr_data & CTRL_KEEP;
    assign rst_ev_stb = ctrl_wr && wr_data[B_RST_EV];
    assign rst_cy_stb = ctrl_wr && wr_data[B_RST_CY];

    assign ev_sel[0] = st_q.sel0;
    assign ev_sel[1] = st_q.sel1;

    // cycle counter and its prescaler
    pmu_slow_tick #(.DIV(SLOW_DIV)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.en && st_q.slow),
        .tick  (slow_tick)
    );

    assign cyc_inc = st_q.en && (st_q.slow ? slow_tick : 1'b1);

    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en && (reg_idx == IDX_CYC)),
        .load_val (wr_data[CNT_W-1:0]),
        .clr      (rst_cy_stb),
        .inc      (cyc_inc),
        .cnt      (cyc_cnt),
        .wrap     (cyc_wrap)
    );

    // event counters
    for (genvar g = 0; g < NUM_EV_CNT; g++) begin : g_ev
        pmu_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
            .evt_in (evt_in),
            .code   (ev_sel[g]),
            .hit    (ev_hit[g])
        );

        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_en && (reg_idx == 2'(IDX_EV0 + g))),
            .load_val (wr_data[CNT_W-1:0]),
            .clr      (rst_ev_stb),
            .inc      (st_q.en && ev_hit[g]),
            .cnt      (ev_cnt[g]),
            .wrap     (ev_wrap[g])
        );
    end

    // control word next state
    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.en   = ctrl_w[B_EN];
            st_d.slow = ctrl_w[B_SLOW];
            st_d.ie   = ctrl_w[B_IE_LSB +: 3];
            st_d.sel0 = ctrl_w[SEL0_LSB +: SEL_W];
            st_d.sel1 = ctrl_w[SEL1_LSB +: SEL_W];
            st_d.ovf  = st_q.ovf & ~ctrl_w[B_OF_LSB +: 3];
        end
        // a new wrap wins over a clear in the same cycle
        st_d.ovf = st_d.ovf | {cyc_wrap, ev_wrap[1], ev_wrap[0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sel0 <= SEL_IDLE;
            st_q.sel1 <= SEL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_flags = st_q.ovf;
    assign ie_bits   = st_q.ie;
    assign irq       = |(ovf_flags & ie_bits);

    always_comb begin
        unique case (reg_idx)
            IDX_CTRL: rd_data = {4'b0, st_q.sel1, st_q.sel0, 1'b0, st_q.ovf,
                                 1'b0, st_q.ie, st_q.slow, 2'b00, st_q.en};
            IDX_CYC:  rd_data = 32'(cyc_cnt);
            IDX_EV0:  rd_data = 32'(ev_cnt[0]);
            default:  rd_data = 32'(ev_cnt[1]);
        endcase
    end
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_idx,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic [31:0]      rd_data,
    input logic             irq,
    input logic [CNT_W-1:0] cyc_cnt,
    input logic [2:0]       ovf_flags,
    input logic             en,
    input logic             slow
);
    logic ctrl_wr, cyc_touch;
    assign ctrl_wr   = wr_en && (reg_idx == 2'd0);
    assign cyc_touch = (wr_en && (reg_idx == 2'd1)) || (ctrl_wr && wr_data[2]);

    // R2
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 2'd0) |-> (rd_data[31:28] == 4'h0 && !rd_data[11] &&
                               !rd_data[7] && rd_data[2:1] == 2'b00));

    // R3
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !slow && !cyc_touch) |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));

    // R3
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cyc_touch) |=> $stable(cyc_cnt));

    // R6
    cyc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[2]) |=> (cyc_cnt == '0));

    // R10
    cyc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == 2'd1) |=> (cyc_cnt == $past(wr_data[CNT_W-1:0])));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flags == 3'b000) |-> !irq);
endmodule

bind perf_mon_unit pmu_chk #(.CNT_W(CNT_W)) u_pmu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .irq       (irq),
    .cyc_cnt   (cyc_cnt),
    .ovf_flags (ovf_flags),
    .en        (st_q.en),
    .slow      (st_q.slow)
);

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
    localparam int NUM_EVT  = 23;
    localparam int SLOW_DIV = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         reg_idx = 2'd0;
    logic               wr_en = 1'b0;
    logic [31:0]        wr_data = '0;
    logic [31:0]        rd_data;
    logic [NUM_EVT-1:0] evt_in = '0;
    logic               irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    perf_mon_unit #(.CNT_W(32), .NUM_EVT(NUM_EVT), .SLOW_DIV(SLOW_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .evt_in(evt_in), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // control word: ie = {cyc, ev1, ev0}, clr = flags to clear {cyc, ev1, ev0}
    function automatic logic [31:0] cw(input bit en, input bit slow, input logic [2:0] ie,
                                       input logic [7:0] s0, input logic [7:0] s1,
                                       input logic [2:0] clr, input bit rst_ev, input bit rst_cy);
        return {4'h0, s1, s0, 1'b0, clr, 1'b0, ie, slow, rst_cy, rst_ev, en};
    endfunction

    task automatic wr(input logic [1:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_idx = idx; wr_data = val; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] val);
        reg_idx = idx;
        #1 val = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(0, v); check("R1 ctrl", v, 32'h0FFF_F000);
        rd(1, v); check("R1 cyc", v, 0);
        rd(2, v); check("R1 ev0", v, 0);
        rd(3, v); check("R1 ev1", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_index_map;
        logic [31:0] v;
        wr(1, 32'h1111_1111); wr(2, 32'h2222_2222); wr(3, 32'h3333_3333);
        rd(1, v); check("R11 idx1", v, 32'h1111_1111);
        rd(2, v); check("R11 idx2", v, 32'h2222_2222);
        rd(3, v); check("R11 idx3", v, 32'h3333_3333);
    endtask

    task automatic t_ctrl_mask;
        logic [31:0] v;
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); check("R2 masked bits", v, 32'h0FFF_F079);
        wr(0, cw(0, 0, 3'b000, 8'hFF, 8'hFF, 3'b111, 0, 0));
        rd(0, v); check("R2 cleared", v, 32'h0FFF_F000);
    endtask

    task automatic t_resets;
        logic [31:0] v;
        wr(1, 7); wr(2, 5); wr(3, 6);
        wr(0, cw(0, 0, 0, 8'hFF, 8'hFF, 0, 1, 0));
        rd(2, v); check("R6 ev0 cleared", v, 0);
        rd(3, v); check("R6 ev1 cleared", v, 0);
        rd(1, v); check("R6 cyc untouched", v, 7);
        wr(0, cw(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 1));
        rd(1, v); check("R6 cyc cleared", v, 0);
    endtask

    task automatic t_cycle_count;
        logic [31:0] a, b;
        wr(0, cw(1, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
        rd(1, a);
        repeat (17) @(negedge clk);
        rd(1, b); check("R3 step per clock", b - a, 17);
        wr(0, cw(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
        rd(1, a);
        repeat (10) @(negedge clk);
        rd(1, b); check("R3 hold when off", b - a, 0);
    endtask

    task automatic t_slow_mode;
        logic [31:0] a, b;
        wr(0, cw(1, 1, 0, 8'hFF, 8'hFF, 0, 0, 0));
        repeat (3) @(negedge clk);
        rd(1, a);
        repeat (5 * SLOW_DIV) @(negedge clk);
        rd(1, b); check("R4 slowed rate", b - a, 5);
        wr(0, cw(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
    endtask

    task automatic t_event_count;
        logic [31:0] v;
        wr(2, 0); wr(3, 0);
        wr(0, cw(1, 0, 0, 8'h05, 8'h06, 0, 0, 0));
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            evt_in = '0;
            evt_in[5] = (i % 3 != 0);
            evt_in[6] = (i % 2 == 0);
        end
        @(negedge clk); evt_in = '0;
        wr(0, cw(0, 0, 0, 8'h05, 8'h06, 0, 0, 0));
        rd(2, v); check("R5 ev0 code 0x05", v, 6);
        rd(3, v); check("R5 ev1 code 0x06", v, 5);
        // idle code and out-of-range code
        wr(0, cw(1, 0, 0, 8'h1F, 8'hFF, 0, 0, 0));
        @(negedge clk); evt_in = '1;
        repeat (4) @(negedge clk);
        evt_in = '0;
        wr(0, cw(0, 0, 0, 8'h05, 8'h06, 0, 0, 0));
        rd(2, v); check("R5 code above range", v, 6);
        rd(3, v); check("R5 idle code 0xFF", v, 5);
        // disabled: pulses ignored
        @(negedge clk); evt_in = '1;
        repeat (4) @(negedge clk);
        evt_in = '0;
        rd(2, v); check("R5 disabled ev0", v, 6);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        wr(0, cw(1, 0, 0, 8'h07, 8'hFF, 0, 0, 0));
        wr(1, 100);
        rd(1, v); check("R10 cyc load wins", v, 100);
        @(negedge clk); evt_in[7] = 1'b1;
        wr(2, 50);
        rd(2, v); check("R10 ev0 load wins", v, 50);
        evt_in = '0;
        wr(0, cw(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
    endtask

    task automatic t_wrap_flags;
        logic [31:0] v;
        wr(2, 32'hFFFF_FFFF);
        wr(0, cw(1, 0, 0, 8'h07, 8'hFF, 0, 0, 0));
        @(negedge clk); evt_in[7] = 1'b1;
        @(negedge clk); evt_in = '0;
        rd(2, v); check("R7 ev0 wrapped", v, 0);
        rd(0, v); check("R7 ev0 flag", {31'b0, v[8]}, 1);
        check("R9 irq masked", {31'b0, irq}, 0);
        wr(0, cw(1, 0, 3'b001, 8'h07, 8'hFF, 0, 0, 0));
        check("R9 irq raised", {31'b0, irq}, 1);
        wr(0, cw(1, 0, 3'b001, 8'h07, 8'hFF, 3'b010, 0, 0));
        rd(0, v); check("R8 other clear keeps flag", {31'b0, v[8]}, 1);
        wr(0, cw(1, 0, 3'b001, 8'h07, 8'hFF, 3'b001, 0, 0));
        rd(0, v); check("R8 flag cleared", {31'b0, v[8]}, 0);
        check("R9 irq dropped", {31'b0, irq}, 0);
        // cycle counter wrap
        wr(0, cw(1, 0, 3'b100, 8'hFF, 8'hFF, 0, 0, 0));
        wr(1, 32'hFFFF_FFFD);
        repeat (3) @(negedge clk);
        rd(1, v); check("R7 cyc wrapped", v, 0);
        rd(0, v); check("R7 cyc flag", {29'b0, v[10:8]}, 3'b100);
        check("R9 irq from cyc", {31'b0, irq}, 1);
        wr(0, cw(0, 0, 0, 8'hFF, 8'hFF, 3'b111, 0, 0));
        check("R9 irq after clear", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index_map();
        t_ctrl_mask();
        t_resets();
        t_cycle_count();
        t_slow_mode();
        t_event_count();
        t_priority();
        t_wrap_flags();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule